// File: doc/BRIEF.md
# Single-Error Hamming Correction Unit

This unit takes a word laid out as an even-parity Hamming codeword and tries to bring it back into line with the code. Bits are numbered by 1-indexed position: input bit `i-1` is position `i`. Positions that are powers of two hold check bits. The check at position `2^k` covers every position up to N whose index has bit `k` set. A word is valid when every such group, its check bit included, XORs to zero.

The unit forms the syndrome from the word. The syndrome is the XOR of the positions of all set bits, and it is the same as the group parities taken as a binary number. There are three outcomes:

- A zero syndrome means the word is already valid, and it passes through.
- A syndrome from 1 to N names one position, and that bit is inverted.
- A syndrome above N cannot point at any bit, so the word is reported as not fixable and passes through exactly as received.

The result is one bit wider than the input. Its top bit is the fixable flag.

A word is offered with `in_valid`. The result appears one clock later in a register, marked by `out_valid`. The unit accepts a word on every cycle outside reset. The width N may be set from 3 to 30 and defaults to 6.

Top module: `hamfix_top`

## Requirements
- R1: `out_result` is N+1 bits wide. Bit N is the fixable flag (1 = fixable, 0 = not fixable), and bits N-1:0 carry the word.
- R2: If the syndrome is zero, the flag is 1 and the word bits equal the input. The syndrome is the XOR of the 1-indexed positions of all set input bits, with even parity in each check group.
- R3: If the syndrome S satisfies 1 <= S <= N, the flag is 1 and the word bits equal the input with position S (bit S-1) inverted. The result is therefore a valid codeword.
- R4: If the syndrome is greater than N, the flag is 0 and the word bits equal the input unchanged.
- R5: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1 and reset was low. It is 0 after an edge at which `in_valid` was 0.
- R6: At an edge where `in_valid` is 0, `out_result` keeps its value, whatever `in_word` holds.
- R7: A synchronous reset clears `out_valid` and `out_result` to zero, even if `in_valid` is high at that edge.
- R8: `in_ready` is 0 while reset is high and 1 otherwise.
- R9: For every input of the default 6-bit width, the result matches R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered this cycle |
| in_ready | output | 1 | Unit accepts a word this cycle |
| in_word | input | N | Received codeword, bit i-1 = position i |
| out_valid | output | 1 | `out_result` holds a fresh result |
| out_result | output | N+1 | {fixable flag, corrected or original word} |

## Verification
The assertions assume that `rst` is driven to a known level from time zero. They also assume that `in_word` is stable around the sampling edge whenever `in_valid` is high, because several checks compare the result with `$past(in_word)`. The bench drives every input on the falling clock edge, and it holds reset high for the first few edges, so both conditions hold. The hold check deliberately changes `in_word` while `in_valid` is low. This is allowed, because no assertion looks at the word on an idle cycle except to require that the output is stable.

// File: rtl/hamfix_pkg.sv
package hamfix_pkg;

  // Largest word width the unit supports, and the syndrome width it needs.
  localparam int MAX_W  = 30;
  localparam int MAX_SW = 5;

  // Coverage mask of check group k for a word of n bits.
  // Bit p-1 is set when 1-indexed position p is at most n and has bit k set.
  function automatic logic [MAX_W-1:0] group_mask(input int k, input int n);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int p = 1; p <= MAX_W; p++) begin
      if (p <= n && ((p >> k) & 1) == 1) m[p-1] = 1'b1;
    end
    return m;
  endfunction

  // Classification of a syndrome against the word width.
  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_FIX   = 2'd1,
    SYN_BAD   = 2'd2
  } syn_class_e;

endpackage

// File: rtl/hamfix_syndrome.sv
module hamfix_syndrome #(
  parameter int N  = 6,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]  word,
  output logic [SW-1:0] syn
);
  import hamfix_pkg::*;

  // One parity tree per check group.
  for (genvar k = 0; k < SW; k++) begin : g_grp
    localparam logic [MAX_W-1:0] FULL_MASK = group_mask(k, N);
    localparam logic [N-1:0]     MASK      = FULL_MASK[N-1:0];
    assign syn[k] = ^(word & MASK);
  end
endmodule

// File: rtl/hamfix_correct.sv
module hamfix_correct #(
  parameter int N  = 6,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]           word,
  input  logic [SW-1:0]          syn,
  output hamfix_pkg::syn_class_e cls,
  output logic                   fixable,
  output logic [N-1:0]           fixed_word
);
  import hamfix_pkg::*;

  logic [N-1:0] flip;
  logic         in_range;

  // Decode the syndrome into a one-hot flip vector over the real positions.
  for (genvar i = 0; i < N; i++) begin : g_flip
    assign flip[i] = (syn == SW'(i + 1));
  end

  assign in_range = (int'(syn) <= N);

  always_comb begin
    if (syn == '0)    cls = SYN_CLEAN;
    else if (in_range) cls = SYN_FIX;
    else              cls = SYN_BAD;
  end

  assign fixable    = (cls != SYN_BAD);
  assign fixed_word = (cls == SYN_FIX) ? (word ^ flip) : word;
endmodule

// File: rtl/hamfix_outreg.sv
module hamfix_outreg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N:0]   d,
  output logic         q_valid,
  output logic [N:0]   q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/hamfix_top.sv
module hamfix_top #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_word,
  output logic         out_valid,
  output logic [N:0]   out_result
);
  import hamfix_pkg::*;

  localparam int SW = $clog2(N + 1);

  logic [SW-1:0] syn;
  syn_class_e    cls;
  logic          fixable;
  logic [N-1:0]  fixed_word;
  logic          accept;

  // Named events, brought out for the checker.
  logic syn_zero;
  logic fix_apply;
  logic no_fix;

  hamfix_syndrome #(.N(N), .SW(SW)) u_syn (
    .word (in_word),
    .syn  (syn)
  );

  hamfix_correct #(.N(N), .SW(SW)) u_cor (
    .word       (in_word),
    .syn        (syn),
    .cls        (cls),
    .fixable    (fixable),
    .fixed_word (fixed_word)
  );

  assign in_ready  = !rst;
  assign accept    = in_valid && in_ready;
  assign syn_zero  = (cls == SYN_CLEAN);
  assign fix_apply = (cls == SYN_FIX);
  assign no_fix    = (cls == SYN_BAD);

  hamfix_outreg #(.N(N)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .d       ({fixable, fixed_word}),
    .q_valid (out_valid),
    .q       (out_result)
  );
endmodule

// File: rtl/hamfix_chk.sv
module hamfix_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_word,
  input logic         out_valid,
  input logic [N:0]   out_result,
  input logic         syn_zero,
  input logic         fix_apply,
  input logic         no_fix
);
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    $countones({syn_zero, fix_apply, no_fix}) == 1);  // R2

  AST_FLAG_FROM_CLASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result[N] == !$past(no_fix));  // R1

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && syn_zero) |=> out_result[N-1:0] == $past(in_word));  // R2

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fix_apply) |=> $countones(out_result[N-1:0] ^ $past(in_word)) == 1);  // R3

  AST_BAD_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_result[N]) |-> out_result[N-1:0] == $past(in_word));  // R4

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));  // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));  // R7

  AST_READY: assert property (@(posedge clk)
    in_ready == !rst);  // R8
endmodule

bind hamfix_top hamfix_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_result (out_result),
  .syn_zero   (syn_zero),
  .fix_apply  (fix_apply),
  .no_fix     (no_fix)
);

// File: tb/hamfix_top_tb.sv
`timescale 1ns/1ps
module hamfix_top_tb;
  localparam int N     = 6;
  localparam int NVEC  = 12;
  localparam int LIMIT = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_word = '0;
  logic         out_valid;
  logic [N:0]   out_result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hamfix_top #(.N(N)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // Hand-worked vectors: {input word} -> {flag, word}.
  localparam logic [N-1:0] VIN [NVEC] = '{
    6'b000000, 6'b000001, 6'b000011, 6'b001100,
    6'b001011, 6'b110000, 6'b111111, 6'b100000,
    6'b110100, 6'b001111, 6'b001010, 6'b100001
  };
  localparam logic [N:0] VEXP [NVEC] = '{
    7'b1000000, 7'b1000000, 7'b1000111, 7'b0001100,
    7'b0001011, 7'b1110100, 7'b0111111, 7'b1000000,
    7'b1110100, 7'b1000111, 7'b1101010, 7'b0100001
  };

  // Reference model: the syndrome is the running XOR of the set positions.
  function automatic logic [N:0] ref_fix(input logic [N-1:0] w);
    int s = 0;
    for (int p = 1; p <= N; p++) if (w[p-1]) s = s ^ p;
    if (s == 0) return {1'b1, w};
    if (s <= N) begin
      logic [N-1:0] c = w;
      c[s-1] = ~c[s-1];
      return {1'b1, c};
    end
    return {1'b0, w};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N:0] held;
    // Reset state.
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", 32'(out_valid), 32'd0);
    check("R7 reset out_result", 32'(out_result), 32'd0);
    check("R8 ready in reset", 32'(in_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", 32'(in_ready), 32'd1);
    check("R5 idle out_valid", 32'(out_valid), 32'd0);

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      apply(VIN[i]);
      if (!VEXP[i][N])                 tag = "R4 unfixable";
      else if (VEXP[i][N-1:0] == VIN[i]) tag = "R2 clean";
      else                             tag = "R3 corrected";
      check("R5 out_valid", 32'(out_valid), 32'd1);
      check(tag, 32'(out_result), 32'(VEXP[i]));
      check("R1 flag", 32'(out_result[N]), 32'(VEXP[i][N]));
    end

    // Hold: in_valid low, word changes, result must not move.
    apply(6'b000011);
    held = out_result;
    in_valid = 1'b0;
    in_word  = 6'b001100;
    @(negedge clk);
    check("R5 out_valid drops", 32'(out_valid), 32'd0);
    check("R6 hold", 32'(out_result), 32'(held));
    in_word = 6'b111111;
    @(negedge clk);
    check("R6 hold again", 32'(out_result), 32'(held));

    // Exhaustive sweep against the reference model.
    for (int v = 0; v < (1 << N); v++) begin
      apply(N'(v));
      check("R9 sweep", 32'(out_result), 32'(ref_fix(N'(v))));
    end

    // Reset with in_valid high clears the output.
    apply(6'b110000);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset clears valid", 32'(out_valid), 32'd0);
    check("R7 reset clears result", 32'(out_result), 32'd0);
    check("R8 ready low in reset", 32'(in_ready), 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R5 no output after reset", 32'(out_valid), 32'd0);
    apply(6'b001010);
    check("R3 after reset", 32'(out_result), 32'(7'b1101010));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule